// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one output cell of a programmable logic device. It takes the sum-of-products term that an upstream product-term array has built, together with a handful of static configuration bits, and produces three things: the value for the pin, the pin's output enable, and a feedback signal that returns to the device's routing. The configuration decides whether the pin sees the sum term directly or a stored copy of it. It also picks the storage rule (load or toggle), the polarity at the pin, which of four clock sources advances the storage, and whether the cell drives its pin at all.

The four clock sources arrive as single-cycle event strobes. They are qualified by the one core clock, so the storage element never runs on a multiplexed clock. A cell set to buried keeps its result on the internal feedback. It releases the pin, and the pin's input value is passed back on a separate pin-feedback output. Configuration is static: it may change only while reset is held.

Top module: `pl_macrocell`

## Requirements
- R1: With cfg_registered=0 and cfg_buried=0, pin_out equals sum_term XOR cfg_invert in the same cycle, with no register in the path.
- R2: With cfg_registered=1 and cfg_buried=0, pin_out equals the stored bit XOR cfg_invert.
- R3: With cfg_toggle=0 (load rule), an enabled clock event stores sum_term, and the stored value is visible on the cycle after the event.
- R4: With cfg_toggle=1 (toggle rule), an enabled clock event inverts the stored bit when sum_term is 1 and leaves it unchanged when sum_term is 0.
- R5: Only strobe bit clk_tick[cfg_clk_sel] advances the storage (cfg_clk_sel is a binary index 0..3). Strobes on the other three bits leave the stored bit unchanged.
- R6: While rst_n is low at a clock edge, the stored bit becomes 0 after that edge, even when a selected strobe and sum_term=1 are present.
- R7: With cfg_buried=1, pin_oe is 0, pin_out is 0, and pin_fb equals pin_in.
- R8: With cfg_buried=0, pin_oe is 1 and pin_fb is 0.
- R9: fb_out carries the stored bit when cfg_registered=1 and sum_term when cfg_registered=0, whether or not the cell is buried.
- R10: cfg_invert acts only after the storage. fb_out and the stored state are the same for either polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset of the stored bit |
| sum_term | input | 1 | Sum-of-products result from the product-term array |
| pin_in | input | 1 | Value sensed on the pin |
| clk_tick | input | 4 | One event strobe per clock source |
| cfg_registered | input | 1 | 1: pin and feedback use the stored bit; 0: use sum_term |
| cfg_toggle | input | 1 | 1: toggle rule; 0: load rule |
| cfg_invert | input | 1 | 1: invert the result before the pin |
| cfg_clk_sel | input | 2 | Binary index of the strobe that advances storage |
| cfg_buried | input | 1 | 1: release the pin and keep the result internal |
| pin_out | output | 1 | Value to drive on the pin |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Cell result fed back into the routing |
| pin_fb | output | 1 | Pin input fed back when buried, else 0 |

## Verification
A wrong stored bit shows on fb_out in the cycle after the bad edge whenever the cell is registered. It also shows on pin_out unless the cell is buried. A fault in the polarity or output-enable logic shows in the same cycle, because those paths are combinational. The bench covers all 64 configuration combinations. In each it compares all four outputs against a behavioural model every cycle, so a wrong strobe selection or a wrong toggle is seen no more than one cycle after the first strobe it affects.

// File: rtl/mc_pkg.sv
// Package: shared constants and helpers for the macrocell.
// Assumes: exactly one clock-source strobe vector per cell.
package mc_pkg;
    localparam int unsigned MC_NUM_CLK = 4;
    localparam int unsigned MC_SEL_W   = $clog2(MC_NUM_CLK);

    // Storage rule applied on an enabled clock event.
    typedef enum logic {
        STORE_LOAD   = 1'b0,
        STORE_TOGGLE = 1'b1
    } store_rule_t;

    // Next stored value for a given rule.
    function automatic logic mc_next(input store_rule_t rule, input logic q, input logic d);
        return (rule == STORE_TOGGLE) ? (q ^ d) : d;
    endfunction
endpackage

// File: rtl/mc_clk_sel.sv
// Module: mc_clk_sel
// Picks one clock-source strobe by binary index and turns it into an update
// enable for the core-clocked storage. Assumes each strobe lasts one cycle and
// sel is static while out of reset.
module mc_clk_sel #(
    parameter int unsigned NUM_CLK = 4,
    localparam int unsigned SEL_W  = $clog2(NUM_CLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLK-1:0] tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               en
);
    logic [NUM_CLK-1:0] sel_hot;
    logic [NUM_CLK-1:0] gated;

    // One decoder slice and one AND gate for each clock source.
    for (genvar i = 0; i < NUM_CLK; i++) begin : g_src
        assign sel_hot[i] = (sel == SEL_W'(i));
        assign gated[i]   = sel_hot[i] & tick[i];
    end

    // Purpose: merge the gated strobes into one update enable.
    always_comb begin
        en = |gated;
    end

    AST_EN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (tick != '0)); // R5
    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gated)); // R5
endmodule

// File: rtl/mc_store.sv
// Module: mc_store
// The cell's one storage bit. On an enabled core-clock edge it loads d or
// toggles on d, as rule selects. A synchronous active-low reset has priority.
// Assumes rule is static while out of reset.
module mc_store
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  store_rule_t rule,
    input  logic        d,
    output logic        q
);
    // Purpose: reset, or apply the storage rule when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (en) begin
            q <= mc_next(rule, q, d);
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (q == 1'b0)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)); // R5
    AST_LOAD_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rule == STORE_LOAD) |=> (q == $past(d))); // R3
    AST_TOGGLE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rule == STORE_TOGGLE) |=> (q == ($past(q) ^ $past(d)))); // R4
endmodule

// File: rtl/mc_out_path.sv
// Module: mc_out_path
// Chooses the cell result (stored or direct) and applies polarity after the
// storage. It also handles pin release in buried mode and steers the pin input
// to pin_fb. Purely combinational; clk and rst_n serve only the checks.
module mc_out_path (
    input  logic clk,
    input  logic rst_n,
    input  logic registered,
    input  logic invert,
    input  logic buried,
    input  logic q,
    input  logic sum_term,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_out,
    output logic pin_fb
);
    logic result;

    // Purpose: select the true-sense result.
    always_comb begin
        result = registered ? q : sum_term;
    end

    // Purpose: drive pin, enable and both feedback paths.
    always_comb begin
        fb_out  = result;
        pin_oe  = ~buried;
        pin_out = buried ? 1'b0 : (result ^ invert);
        pin_fb  = buried ? pin_in : 1'b0;
    end

    AST_BURIED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        buried |-> (!pin_oe && !pin_out && pin_fb == pin_in)); // R7
    AST_DRIVEN_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !buried |-> (pin_oe && !pin_fb)); // R8
    AST_POLARITY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        !buried |-> (pin_out == (fb_out ^ invert))); // R10
endmodule

// File: rtl/pl_macrocell.sv
// Module: pl_macrocell (top)
// One configurable output cell: strobe selection, load/toggle storage,
// output and feedback steering. Assumes all cfg_* inputs change only while
// rst_n is low, and that each clock source arrives as a one-cycle strobe
// synchronous to clk.
module pl_macrocell
    import mc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sum_term,
    input  logic                pin_in,
    input  logic [MC_NUM_CLK-1:0] clk_tick,
    input  logic                cfg_registered,
    input  logic                cfg_toggle,
    input  logic                cfg_invert,
    input  logic [MC_SEL_W-1:0] cfg_clk_sel,
    input  logic                cfg_buried,
    output logic                pin_out,
    output logic                pin_oe,
    output logic                fb_out,
    output logic                pin_fb
);
    logic        upd_en;
    logic        stored;
    store_rule_t rule;

    // Purpose: map the toggle bit onto the storage rule type.
    always_comb begin
        rule = cfg_toggle ? STORE_TOGGLE : STORE_LOAD;
    end

    mc_clk_sel #(.NUM_CLK(MC_NUM_CLK)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (clk_tick),
        .sel   (cfg_clk_sel),
        .en    (upd_en)
    );

    mc_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (upd_en),
        .rule  (rule),
        .d     (sum_term),
        .q     (stored)
    );

    mc_out_path u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .registered (cfg_registered),
        .invert     (cfg_invert),
        .buried     (cfg_buried),
        .q          (stored),
        .sum_term   (sum_term),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .fb_out     (fb_out),
        .pin_fb     (pin_fb)
    );

    AST_DIRECT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_registered && !cfg_buried) |-> (pin_out == (sum_term ^ cfg_invert))); // R1
    AST_FB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_registered |-> (fb_out == sum_term)); // R9
endmodule

// File: tb/tb_pl_macrocell.sv
// Bench: every configuration combination checked against a behavioural model
// on every cycle.
module tb_pl_macrocell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sum_term = 1'b0;
    logic       pin_in = 1'b0;
    logic [3:0] clk_tick = '0;
    logic       cfg_registered = 1'b0;
    logic       cfg_toggle = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_clk_sel = '0;
    logic       cfg_buried = 1'b0;
    logic       pin_out, pin_oe, fb_out, pin_fb;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit model_q = 1'b0;
    string last_tag = "R6";

    always #4 clk = ~clk;   // 125 MHz

    pl_macrocell dut (
        .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .pin_in(pin_in),
        .clk_tick(clk_tick), .cfg_registered(cfg_registered),
        .cfg_toggle(cfg_toggle), .cfg_invert(cfg_invert),
        .cfg_clk_sel(cfg_clk_sel), .cfg_buried(cfg_buried),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .pin_fb(pin_fb)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b (reg=%0b tog=%0b inv=%0b sel=%0d bur=%0b)",
                     tag, what, act, exp, cfg_registered, cfg_toggle, cfg_invert,
                     cfg_clk_sel, cfg_buried);
        end
    endtask

    // Drive one cycle's inputs at the falling edge, compare mid-phase, then
    // advance the model at the rising edge.
    task automatic step(input bit r_n, input bit s, input bit p, input logic [3:0] t);
        bit res;
        @(negedge clk);
        rst_n = r_n; sum_term = s; pin_in = p; clk_tick = t;
        #2;
        res = cfg_registered ? model_q : s;
        if (cfg_buried) begin
            check("R7", "pin_oe", pin_oe, 1'b0);
            check("R7", "pin_out", pin_out, 1'b0);
            check("R7", "pin_fb", pin_fb, p);
        end else begin
            check("R8", "pin_oe", pin_oe, 1'b1);
            check("R8", "pin_fb", pin_fb, 1'b0);
            check(cfg_registered ? "R2" : "R1", "pin_out", pin_out, res ^ cfg_invert);
        end
        if (!cfg_registered)
            check("R9", "fb_out", fb_out, s);
        else if (cfg_invert)
            check("R10", "fb_out", fb_out, model_q);
        else
            check(last_tag, "fb_out", fb_out, model_q);
        @(posedge clk);
        if (!r_n) begin
            model_q = 1'b0; last_tag = "R6";
        end else if (t[cfg_clk_sel]) begin
            model_q = cfg_toggle ? (model_q ^ s) : s;
            last_tag = cfg_toggle ? "R4" : "R3";
        end else if (t != 4'b0) begin
            last_tag = "R5";
        end
    endtask

    initial begin
        for (int c = 0; c < 64; c++) begin
            // Configuration changes only while reset is held.
            step(1'b0, 1'b1, 1'b0, 4'hF);
            {cfg_registered, cfg_toggle, cfg_invert, cfg_clk_sel, cfg_buried} = 6'(c);
            step(1'b0, 1'b1, 1'b1, 4'hF);   // R6: reset beats a selected strobe
            step(1'b0, 1'b0, 1'b0, 4'h0);
            // Directed: strobe set to one on every source but the selected one (R5).
            step(1'b1, 1'b1, 1'b1, ~(4'b1 << cfg_clk_sel));
            step(1'b1, 1'b1, 1'b0, 4'b1 << cfg_clk_sel);
            step(1'b1, 1'b1, 1'b1, 4'b1 << cfg_clk_sel);
            step(1'b1, 1'b0, 1'b0, 4'b1 << cfg_clk_sel);
            for (int k = 0; k < 24; k++) begin
                step(($urandom_range(0, 15) != 0), 1'($urandom), 1'($urandom),
                     4'($urandom));
            end
            step(1'b1, 1'b0, 1'b1, 4'h0);
        end
        done = 1'b1;
    end

    initial begin
        for (int w = 0; w < 100000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule